// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block produces the frequency-offset word that a fractional feedback divider adds to its nominal ratio. The aim is to sweep the synthesized frequency slowly so that its spectral energy spreads out and peak EMI drops. It runs on the reference clock. From a static setting it produces one signed offset each cycle, in units of 2^-20 of the nominal ratio. The setting holds a spread shape (symmetric about nominal, or below nominal only), a deviation code, and a modulation period counted in reference cycles. The offset follows a linear triangle. It rises from the low extreme to the high extreme over half the period, then falls back over the other half.

The output is a free-running stream with no valid or ready pair. The divider takes a fresh word every reference cycle and cannot apply back-pressure, so the profile never stalls. A setting whose period is too short, or whose code is outside the range allowed for the chosen shape, raises an error flag and holds the offset at zero. When spread is off or the code is zero, the offset is zero and the flag stays low. Any other change to the setting waits for the current period to end, so the divider never sees a jump in the middle of a sweep.

Top module: `ssc_profile_gen`

## Requirements
- R1: While rst_n is low, offset_word is 0 and cfg_err is 0, whatever the other inputs are.
- R2: With spread_dn=0 and dev_code n in 1..24, the amplitude is A=floor(n*2^20/800). The profile runs between lo=-A and hi=+A.
- R3: With spread_dn=1 and dev_code n in 1..16, the depth is D=floor(n*2^20/400). The profile runs between lo=-D and hi=0, so its top sits exactly at nominal.
- R4: Let H=floor(mod_period/2) and span=hi-lo. A modulation period lasts 2H cycles. In cycle k of a period (k=0 first), offset_word is lo+floor(span*k/H) for k<=H, and hi-floor(span*(k-H)/H) for H<k<2H.
- R5: In each period, hi appears only at k=H, where the ramp turns downward. lo appears only at k=0. After cycle 2H-1 the next cycle is k=0 of a new period.
- R6: With ssc_en=1 and dev_code nonzero, a mod_period below 225 makes cfg_err 1 and offset_word 0 one cycle later. A mod_period of 225 is accepted.
- R7: With ssc_en=1, a dev_code above 24 (spread_dn=0) or above 16 (spread_dn=1) makes cfg_err 1 and offset_word 0 one cycle later. A code that is out of range for one shape can still be valid for the other.
- R8: ssc_en=0 or dev_code=0 gives offset_word 0 and cfg_err 0 one cycle later. On the first valid cycle after that, the profile restarts at k=0 with offset lo.
- R9: A change to spread_dn, dev_code or mod_period that leaves the setting valid has no effect on offset_word until the current period has finished. The new setting first applies at the next k=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssc_en | input | 1 | Spread modulation on |
| spread_dn | input | 1 | 0: symmetric about nominal, 1: below nominal only |
| dev_code | input | DCW (5) | Deviation step count |
| mod_period | input | PW (16) | Reference cycles per modulation period |
| offset_word | output | OW (20) | Signed divider offset, units of 2^-20 |
| cfg_err | output | 1 | Setting is invalid; offset held at 0 |

## Verification
Both outputs are registered, so every result is due exactly one rising edge after the inputs that caused it are sampled. New settings therefore show either in the next cycle (error, disable) or at the next k=0 of the triangle. The driver changes inputs just after a rising edge. For each cycle it queues the value an independent model predicts, tagged with the cycle in which that value must appear. The monitor compares at the falling edge of exactly that cycle. This makes an early or late restart, or a setting taken up mid-period, show up as a mismatch.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // fractional resolution of the offset word
  localparam int unsigned FRAC_BITS = 20;

  // highest legal deviation code per spread shape
  localparam int unsigned CENTER_CODE_MAX = 24;
  localparam int unsigned DOWN_CODE_MAX   = 16;

  // 0.125 % = 1/800, 0.25 % = 1/400; truncation rounds toward nominal
  function automatic longint unsigned peak_units(input logic dn, input int unsigned code);
    longint unsigned num;
    num = longint'(code) << FRAC_BITS;
    return dn ? (num / 400) : (num / 800);
  endfunction

endpackage

// File: rtl/ssc_cfg_check.sv
module ssc_cfg_check #(
  parameter int DCW        = 5,
  parameter int PW         = 16,
  parameter int OW         = 20,
  parameter int MIN_PERIOD = 225
) (
  input  logic                 en,
  input  logic                 dn,
  input  logic [DCW-1:0]       code,
  input  logic [PW-1:0]        period,
  output logic                 go,
  output logic                 bad,
  output logic signed [OW-1:0] lo,
  output logic [OW-1:0]        span,
  output logic [PW-1:0]        half
);
  localparam int NCODE = 2 ** DCW;

  logic [OW-1:0] lut_ctr [NCODE];
  logic [OW-1:0] lut_dn  [NCODE];

  // deviation tables computed per code
  for (genvar i = 0; i < NCODE; i++) begin : g_lut
    assign lut_ctr[i] = OW'(ssc_pkg::peak_units(1'b0, i));
    assign lut_dn[i]  = OW'(ssc_pkg::peak_units(1'b1, i));
  end

  logic [OW-1:0] pk;
  logic          active, code_bad, per_bad;

  always_comb begin
    pk       = dn ? lut_dn[code] : lut_ctr[code];
    active   = en && (code != '0);
    code_bad = dn ? (int'(code) > int'(ssc_pkg::DOWN_CODE_MAX))
                  : (int'(code) > int'(ssc_pkg::CENTER_CODE_MAX));
    per_bad  = (int'(period) < MIN_PERIOD);
    bad      = active && (code_bad || per_bad);
    go       = active && !bad;
    lo       = -$signed(pk);
    span     = dn ? pk : (pk << 1);
    half     = period >> 1;
  end
endmodule

// File: rtl/ssc_step_calc.sv
module ssc_step_calc #(
  parameter int PW = 16,
  parameter int OW = 20
) (
  input  logic [OW-1:0] span,
  input  logic [PW-1:0] half,
  output logic [OW-1:0] quo,
  output logic [PW-1:0] rem
);
  localparam int XW = (OW > PW) ? OW : PW;

  logic [XW-1:0] span_x, half_x, quo_x, rem_x;

  always_comb begin
    span_x = XW'(span);
    half_x = XW'(half);
    if (half_x == '0) begin
      quo_x = '0;
      rem_x = '0;
    end else begin
      quo_x = span_x / half_x;
      rem_x = span_x % half_x;
    end
    quo = OW'(quo_x);
    rem = PW'(rem_x);
  end
endmodule

// File: rtl/ssc_tri_core.sv
module ssc_tri_core #(
  parameter int PW = 16,
  parameter int OW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic signed [OW-1:0] lo,
  input  logic [OW-1:0]        span,
  input  logic [PW-1:0]        half,
  input  logic [OW-1:0]        quo,
  input  logic [PW-1:0]        rem,
  output logic signed [OW-1:0] offset
);
  logic                 run_q, dir_q;
  logic [PW-1:0]        t_q, acc_q, h_q, r_q;
  logic [OW-1:0]        q_q;
  logic signed [OW-1:0] off_q, lo_q, hi_q;

  logic                 last, start, carry;
  logic [PW:0]          acc_sum, acc_nx;
  logic [OW-1:0]        delta;
  logic signed [OW-1:0] off_step;

  always_comb begin
    last     = (t_q == h_q - PW'(1));
    start    = go && (!run_q || (dir_q && last));
    acc_sum  = {1'b0, acc_q} + {1'b0, r_q};
    carry    = (acc_sum >= {1'b0, h_q});
    acc_nx   = carry ? (acc_sum - {1'b0, h_q}) : acc_sum;
    delta    = q_q + OW'(carry);
    off_step = dir_q ? (off_q - $signed(delta)) : (off_q + $signed(delta));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; dir_q <= 1'b0; t_q <= '0; acc_q <= '0;
      h_q <= '0; r_q <= '0; q_q <= '0;
      off_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (!go) begin
      run_q <= 1'b0; dir_q <= 1'b0; t_q <= '0; acc_q <= '0;
      off_q <= '0;
    end else if (start) begin
      run_q <= 1'b1; dir_q <= 1'b0; t_q <= '0; acc_q <= '0;
      lo_q  <= lo;
      hi_q  <= lo + $signed(span);
      h_q   <= half;
      q_q   <= quo;
      r_q   <= rem;
      off_q <= lo;
    end else begin
      off_q <= off_step;
      if (last) begin
        dir_q <= ~dir_q;
        t_q   <= '0;
        acc_q <= '0;
      end else begin
        t_q   <= t_q + PW'(1);
        acc_q <= acc_nx[PW-1:0];
      end
    end
  end

  assign offset = off_q;

  // R4
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (off_q >= lo_q && off_q <= hi_q));
  // R4
  ramp_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !dir_q && t_q != '0) |-> (off_q >= $past(off_q)));
  // R5
  flip_at_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $rose(dir_q)) |-> (off_q == hi_q));
  // R5
  restart_at_trough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $fell(dir_q)) |-> (off_q == lo_q));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (dir_q || t_q != '0)) |-> ($stable(h_q) && $stable(lo_q) && $stable(q_q)));
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int DCW        = 5,
  parameter int PW         = 16,
  parameter int OW         = 20,
  parameter int MIN_PERIOD = 225
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic                 ssc_en,
  input  logic                 spread_dn,
  input  logic [DCW-1:0]       dev_code,
  input  logic [PW-1:0]        mod_period,
  output logic signed [OW-1:0] offset_word,
  output logic                 cfg_err
);
  logic                 go, bad;
  logic signed [OW-1:0] lo;
  logic [OW-1:0]        span, quo;
  logic [PW-1:0]        half, rem;
  logic                 err_q;

  ssc_cfg_check #(.DCW(DCW), .PW(PW), .OW(OW), .MIN_PERIOD(MIN_PERIOD)) u_cfg (
    .en(ssc_en), .dn(spread_dn), .code(dev_code), .period(mod_period),
    .go(go), .bad(bad), .lo(lo), .span(span), .half(half)
  );

  ssc_step_calc #(.PW(PW), .OW(OW)) u_step (
    .span(span), .half(half), .quo(quo), .rem(rem)
  );

  ssc_tri_core #(.PW(PW), .OW(OW)) u_core (
    .clk(clk_ref), .rst_n(rst_n), .go(go), .lo(lo), .span(span), .half(half),
    .quo(quo), .rem(rem), .offset(offset_word)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad;
  end

  assign cfg_err = err_q;

  // R6
  err_zero_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cfg_err |-> (offset_word == '0));
  // R8
  off_when_disabled_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ssc_en |=> (offset_word == '0 && !cfg_err));
endmodule

// File: tb/sim_ssc_profile_gen.sv
`timescale 1ns/1ps
module sim_ssc_profile_gen;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ssc_en = 1'b0, spread_dn = 1'b0;
  logic [4:0]        dev_code = '0;
  logic [15:0]       mod_period = '0;
  logic signed [19:0] offset_word;
  logic              cfg_err;

  always #2 clk = ~clk;  // 250 MHz

  ssc_profile_gen u0 (
    .clk_ref(clk), .rst_n(rst_n), .ssc_en(ssc_en), .spread_dn(spread_dn),
    .dev_code(dev_code), .mod_period(mod_period),
    .offset_word(offset_word), .cfg_err(cfg_err)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  int    q_due[$], q_val[$];
  bit    q_err[$];
  string q_tag[$];

  // model state
  bit      m_run = 1'b0;
  longint  m_k, m_lo, m_span, m_h;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint peak(input bit dn, input int code);
    longint n;
    n = longint'(code) * 1048576;
    return dn ? n / 400 : n / 800;
  endfunction

  task automatic one_cycle(input bit en, input bit dn, input int code, input int per, input string tag);
    bit active, bad, go;
    longint val;
    @(posedge clk); #1;
    ssc_en = en; spread_dn = dn; dev_code = 5'(code); mod_period = 16'(per);
    active = en && code != 0;
    bad = active && ((dn ? code > 16 : code > 24) || per < 225);
    go = active && !bad;
    if (!go) begin
      m_run = 1'b0; val = 0;
    end else if (!m_run || m_k == 2 * m_h - 1) begin
      m_h = per / 2;
      m_span = dn ? peak(dn, code) : 2 * peak(dn, code);
      m_lo = -peak(dn, code);
      m_k = 0; m_run = 1'b1; val = m_lo;
    end else begin
      m_k++;
      if (m_k <= m_h) val = m_lo + (m_span * m_k) / m_h;
      else            val = m_lo + m_span - (m_span * (m_k - m_h)) / m_h;
    end
    q_due.push_back(cyc + 1); q_val.push_back(int'(val));
    q_err.push_back(bad); q_tag.push_back(tag);
  endtask

  task automatic run(input bit en, input bit dn, input int code, input int per, input int n, input string tag);
    for (int i = 0; i < n; i++) one_cycle(en, dn, code, per, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      int ev; bit ee; string tg;
      ev = q_val.pop_front(); ee = q_err.pop_front(); tg = q_tag.pop_front();
      void'(q_due.pop_front());
      tests++;
      if (int'(offset_word) != ev || cfg_err != ee) begin
        fails++;
        $display("FAIL %s cycle %0d: offset=%0d err=%0b expected offset=%0d err=%0b",
                 tg, cyc, offset_word, cfg_err, ev, ee);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("[TB] watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a valid setting
    ssc_en = 1'b1; dev_code = 5'd8; mod_period = 16'd230;
    repeat (4) @(posedge clk);
    @(negedge clk);
    tests++;
    if (offset_word != 0) begin
      fails++; $display("FAIL R1 offset=%0d expected 0", offset_word);
    end
    tests++;
    if (cfg_err != 1'b0) begin
      fails++; $display("FAIL R1 err=%0b expected 0", cfg_err);
    end
    @(posedge clk); #1;
    ssc_en = 1'b0; rst_n = 1'b1;

    run(1, 0, 8, 230, 600, "R2 R4 R5");
    run(1, 0, 8, 231, 300, "R4");          // odd period
    run(0, 0, 0, 0, 3, "R8");
    run(1, 1, 16, 240, 500, "R3 R4 R5");
    run(1, 1, 1, 1000, 1100, "R3");
    run(1, 0, 24, 226, 240, "R2");
    // R9: valid change mid-period waits for period end
    run(1, 0, 4, 226, 50, "R9");
    run(1, 1, 6, 300, 400, "R9");
    // R8: disable and zero code, then restart from lo
    run(0, 1, 6, 300, 4, "R8");
    run(1, 1, 6, 300, 20, "R8");
    run(1, 1, 0, 300, 3, "R8");
    run(1, 1, 6, 300, 10, "R8");
    run(0, 0, 8, 10, 3, "R8");
    // R6: period limit and its boundary
    run(1, 0, 8, 224, 5, "R6");
    run(1, 0, 8, 225, 240, "R6");
    // R7: code range per shape
    run(1, 0, 25, 400, 5, "R7");
    run(1, 1, 17, 400, 5, "R7");
    run(1, 1, 20, 400, 5, "R7");
    run(1, 0, 20, 400, 30, "R7");

    repeat (3) @(posedge clk);
    @(negedge clk);
    if (q_due.size() != 0) begin
      tests++; fails++;
      $display("FAIL R4 queue left=%0d expected 0", q_due.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule